// File: doc/BRIEF.md
# Clock-Master Serial Byte Receiver with Optional Double Buffering

This block receives bytes over a synchronous serial line and drives the shift clock itself. While it is enabled it sends out bursts of eight clock pulses. On each rising clock edge it samples the incoming data line, least significant bit first. Each finished byte goes into a holding register that the host reads, and a one-cycle interrupt pulse marks the moment it arrives. The half-period of the serial clock comes from a programmable divider of the system clock. Between bursts the serial clock rests high.

A configuration input selects one of two buffering modes. In single mode, the shift register is the only staging stage, and the block waits for the host to read each byte before it starts the next burst. In double mode, a finished byte moves into the holding register and the next burst starts at once. If a second byte finishes while the holding register is still unread, the block keeps that byte in the shift register, raises no interrupt and leaves the clock parked high. No byte is ever lost this way. A host read then moves the kept byte across, pulses the interrupt and restarts reception.

Top module: `serrx_top`

## Requirements
- R1: After reset, `sclkOut` is 1, `bufFull` is 0 and `rxIrq` is 0.
- R2: Inside a burst, every low and high phase of `sclkOut` lasts `divHalf`+1 system clocks. Outside a burst, `sclkOut` stays at 1.
- R3: A frame is exactly 8 rising edges of `sclkOut`. `sdIn` is sampled on each rising edge, and the first bit sampled becomes bit 0 of `rdData`, the last becomes bit 7.
- R4: A burst starts only while `rxEnable` is 1. If `rxEnable` drops during a frame, that frame still completes and is delivered, and no further burst follows.
- R5: In single mode (`dblBuf`=0), a finished byte appears on `rdData` with `bufFull`=1 and one `rxIrq` pulse. No further clock pulse is issued until the host reads.
- R6: In double mode (`dblBuf`=1), the next burst begins as soon as a byte moves into the holding register, even while that register is still unread.
- R7: In double mode, a frame that finishes while the holding register is full raises no `rxIrq`, and `sclkOut` stays at 1 until the host reads.
- R8: A read in that stalled state moves the kept byte across. In the cycle after the read strobe, `rdData` holds that byte, `rxIrq` is 1 and `bufFull` stays 1. Reception then resumes.
- R9: `rxIrq` is a single-cycle pulse. A read with no byte waiting clears `bufFull` in the next cycle.
- R10: A read strobe while `bufFull` is 0 changes nothing: `bufFull` and `rxIrq` stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxEnable | input | 1 | Allows new bursts to start |
| dblBuf | input | 1 | 1 selects double buffering, 0 selects single |
| divHalf | input | DIV_W | Serial clock half-period minus one, in system clocks |
| sdIn | input | 1 | Serial data line |
| rdStrobe | input | 1 | Host read of the holding register |
| rdData | output | DATA_W | Holding register contents |
| bufFull | output | 1 | Holding register holds an unread byte |
| rxIrq | output | 1 | One-cycle pulse when a byte enters the holding register |
| sclkOut | output | 1 | Generated serial clock, idles high |

## Verification
A byte's last bit is shifted in on the eighth rising serial edge. The byte reaches the holding register one system clock later, and `rxIrq`, `bufFull` and `rdData` change together at that edge. The bench therefore waits for the interrupt and samples all three in that same half cycle. A read strobe takes effect at the next rising system edge. The bench drives the strobe for one cycle from a falling edge and checks `bufFull`, `rxIrq` and `rdData` at the following falling edge. Phase lengths and edge counts come from a monitor that samples `sclkOut` at every falling system edge. The stall checks look for the absence of serial edges and interrupts over a window several frames long.

// File: rtl/serrx_pkg.sv
package serrx_pkg;
  typedef struct packed {
    logic shiftEn;   // capture one serial bit into the shift register
    logic loadHold;  // copy the shift register into the holding register
  } rxStrobes_t;
endpackage

// File: rtl/serrx_datapath.sv
module serrx_datapath
  import serrx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobes_t        strobes,
  input  logic              sdIn,
  output logic [DATA_W-1:0] holdData
);
  logic [DATA_W-1:0] shiftReg;

  // LSB-first: each new bit enters at the top and moves down
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobes.shiftEn) begin
      shiftReg <= {sdIn, shiftReg[DATA_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdData <= '0;
    end else if (strobes.loadHold) begin
      holdData <= shiftReg;
    end
  end
endmodule

// File: rtl/serrx_control.sv
module serrx_control
  import serrx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxEnable,
  input  logic             dblBuf,
  input  logic [DIV_W-1:0] divHalf,
  input  logic             rdStrobe,
  output rxStrobes_t       strobes,
  output logic             sclkOut,
  output logic             bufFull,
  output logic             rxIrq,
  output logic             pending,
  output logic             running
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] bitCnt;
  logic             sclkR;
  logic             holdValid;
  logic             irqR;
  logic             tick, riseEdge, frameDone, doMove, startOk;

  always_comb begin
    tick      = running && (divCnt == divHalf);
    riseEdge  = tick && !sclkR;
    frameDone = riseEdge && (bitCnt == LAST_BIT);
    // the kept byte moves once the holding register is free or being read
    doMove    = pending && (!holdValid || rdStrobe);
    // single mode waits for the host; double mode only for the shift register
    startOk   = rxEnable && !running && !pending && (dblBuf || !holdValid);
    strobes.shiftEn  = riseEdge;
    strobes.loadHold = doMove;
  end

  // serial clock generator and bit counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      divCnt  <= '0;
      bitCnt  <= '0;
      sclkR   <= 1'b1;
    end else if (startOk) begin
      running <= 1'b1;
      divCnt  <= '0;
      bitCnt  <= '0;
    end else if (running) begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (tick)      sclkR   <= !sclkR;
      if (riseEdge)  bitCnt  <= bitCnt + 1'b1;
      if (frameDone) running <= 1'b0;
    end
  end

  // buffer hand-over and interrupt
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending   <= 1'b0;
      holdValid <= 1'b0;
      irqR      <= 1'b0;
    end else begin
      if (frameDone)   pending <= 1'b1;
      else if (doMove) pending <= 1'b0;
      if (doMove)        holdValid <= 1'b1;
      else if (rdStrobe) holdValid <= 1'b0;
      irqR <= doMove;
    end
  end

  assign sclkOut = sclkR;
  assign bufFull = holdValid;
  assign rxIrq   = irqR;
endmodule

// File: rtl/serrx_top.sv
module serrx_top
  import serrx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEnable,
  input  logic              dblBuf,
  input  logic [DIV_W-1:0]  divHalf,
  input  logic              sdIn,
  input  logic              rdStrobe,
  output logic [DATA_W-1:0] rdData,
  output logic              bufFull,
  output logic              rxIrq,
  output logic              sclkOut
);
  rxStrobes_t strobes;
  logic       ctrlPending;
  logic       ctrlRunning;

  serrx_control #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rxEnable (rxEnable),
    .dblBuf   (dblBuf),
    .divHalf  (divHalf),
    .rdStrobe (rdStrobe),
    .strobes  (strobes),
    .sclkOut  (sclkOut),
    .bufFull  (bufFull),
    .rxIrq    (rxIrq),
    .pending  (ctrlPending),
    .running  (ctrlRunning)
  );

  serrx_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .sdIn     (sdIn),
    .holdData (rdData)
  );
endmodule

// File: rtl/serrx_checker.sv
module serrx_checker (
  input logic clk,
  input logic rstN,
  input logic rxEnable,
  input logic rdStrobe,
  input logic sclkOut,
  input logic bufFull,
  input logic rxIrq,
  input logic stallPend,
  input logic running
);
  p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |=> !rxIrq);

  p_irq_full_r5: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> bufFull);

  p_stall_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    stallPend |-> sclkOut);

  p_idle_high_r2: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> sclkOut);

  p_read_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && bufFull && !stallPend) |=> !bufFull);

  p_stall_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && bufFull && stallPend) |=> (bufFull && rxIrq));

  p_no_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEnable && !running) |=> !running);
endmodule

bind serrx_top serrx_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .rxEnable  (rxEnable),
  .rdStrobe  (rdStrobe),
  .sclkOut   (sclkOut),
  .bufFull   (bufFull),
  .rxIrq     (rxIrq),
  .stallPend (ctrlPending),
  .running   (ctrlRunning)
);

// File: tb/tb_serrx_top.sv
module tb_serrx_top;
  localparam int DATA_W = 8;
  localparam int DIV_W  = 8;
  localparam int NVEC   = 6;

  // {dblBuf, divHalf, byte}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b0, 8'd0, 8'hA5}, {1'b1, 8'd0, 8'h3C}, {1'b0, 8'd3, 8'h01},
    {1'b1, 8'd2, 8'h80}, {1'b0, 8'd1, 8'hFF}, {1'b1, 8'd5, 8'h00}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              rxEnable = 1'b0;
  logic              dblBuf = 1'b0;
  logic [DIV_W-1:0]  divHalf = '0;
  logic              sdIn = 1'b0;
  logic              rdStrobe = 1'b0;
  logic [DATA_W-1:0] rdData;
  logic              bufFull, rxIrq, sclkOut;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  // serial slave model and clock monitor
  logic [7:0] slaveQ [32];
  int qWr = 0, qRd = 0, slaveBit = 0;
  logic prevSclk = 1'b1;
  int risesCnt = 0, lowCnt = 0, lastLow = 0;

  serrx_top #(.DATA_W(DATA_W), .DIV_W(DIV_W)) dut (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .dblBuf(dblBuf),
    .divHalf(divHalf), .sdIn(sdIn), .rdStrobe(rdStrobe), .rdData(rdData),
    .bufFull(bufFull), .rxIrq(rxIrq), .sclkOut(sclkOut)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (prevSclk && !sclkOut) begin
      sdIn <= slaveQ[qRd][slaveBit];
      if (slaveBit == 7) begin
        slaveBit = 0;
        qRd = qRd + 1;
      end else begin
        slaveBit = slaveBit + 1;
      end
    end
    if (!prevSclk && sclkOut) begin
      risesCnt = risesCnt + 1;
      lastLow  = lowCnt;
      lowCnt   = 0;
    end
    if (!sclkOut) lowCnt = lowCnt + 1;
    prevSclk = sclkOut;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pushByte(input logic [7:0] b);
    slaveQ[qWr] = b;
    qWr = qWr + 1;
  endtask

  task automatic waitIrq(input string req, output bit got);
    got = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (rxIrq) begin
        got = 1'b1;
        break;
      end
    end
    check(got, req, "interrupt arrived", int'(got), 1);
  endtask

  task automatic quietFor(input int n, output int irqs);
    irqs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rxIrq) irqs++;
    end
  endtask

  task automatic readPulse();
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) slaveQ[i] = 8'h00;
    wait (cycles > 150000);
    check(1'b0, "R1", "watchdog expired", cycles, 150000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    bit got;
    int irqs, rb;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(sclkOut == 1'b1, "R1", "sclk at reset", sclkOut, 1);
    check(bufFull == 1'b0, "R1", "bufFull at reset", bufFull, 0);
    check(rxIrq == 1'b0, "R1", "irq at reset", rxIrq, 0);
    rstN = 1'b1;
    quietFor(20, irqs);
    check(risesCnt == 0, "R4", "no burst while disabled", risesCnt, 0);

    // R10 read while empty
    readPulse();
    check(bufFull == 1'b0 && rxIrq == 1'b0, "R10", "read while empty",
          {bufFull, rxIrq}, 0);

    // vector table: one byte per entry
    for (int v = 0; v < NVEC; v++) begin
      dblBuf  = VEC[v][16];
      divHalf = VEC[v][15:8];
      pushByte(VEC[v][7:0]);
      rb = risesCnt;
      rxEnable = 1'b1;
      waitIrq("R5", got);
      rxEnable = 1'b0;
      check(rdData == VEC[v][7:0], "R3", "byte LSB first", rdData, VEC[v][7:0]);
      check(bufFull == 1'b1, "R5", "bufFull with irq", bufFull, 1);
      check(risesCnt - rb == 8, "R3", "rises per frame", risesCnt - rb, 8);
      check(lastLow == int'(VEC[v][15:8]) + 1, "R2", "low phase length",
            lastLow, int'(VEC[v][15:8]) + 1);
      @(negedge clk);
      check(rxIrq == 1'b0, "R9", "irq single cycle", rxIrq, 0);
      readPulse();
      check(bufFull == 1'b0, "R9", "read clears bufFull", bufFull, 0);
    end

    // R5 single mode waits for read before next burst
    dblBuf = 1'b0; divHalf = 8'd1;
    pushByte(8'h5A); pushByte(8'hC3);
    rxEnable = 1'b1;
    waitIrq("R5", got);
    rb = risesCnt;
    quietFor(100, irqs);
    check(risesCnt == rb, "R5", "no clock until read", risesCnt - rb, 0);
    check(sclkOut == 1'b1, "R2", "sclk idles high", sclkOut, 1);
    check(rdData == 8'h5A, "R5", "single byte held", rdData, 8'h5A);
    readPulse();
    check(bufFull == 1'b0, "R9", "single read clears", bufFull, 0);
    waitIrq("R5", got);
    rxEnable = 1'b0;
    check(rdData == 8'hC3, "R5", "next byte after read", rdData, 8'hC3);
    readPulse();

    // R6/R7/R8 double-buffer stall and release
    dblBuf = 1'b1; divHalf = 8'd1;
    pushByte(8'h11); pushByte(8'h96); pushByte(8'h4E);
    rxEnable = 1'b1;
    waitIrq("R6", got);
    rb = risesCnt;
    quietFor(200, irqs);
    check(risesCnt - rb == 8, "R6", "next burst ran while full", risesCnt - rb, 8);
    check(irqs == 0, "R7", "no irq while stalled", irqs, 0);
    check(sclkOut == 1'b1, "R7", "sclk parked high", sclkOut, 1);
    check(rdData == 8'h11, "R7", "first byte still held", rdData, 8'h11);
    readPulse();
    check(rxIrq == 1'b1, "R8", "irq on release", rxIrq, 1);
    check(bufFull == 1'b1, "R8", "bufFull stays set", bufFull, 1);
    check(rdData == 8'h96, "R8", "kept byte moved", rdData, 8'h96);
    rb = risesCnt;
    quietFor(200, irqs);
    check(risesCnt - rb == 8, "R8", "reception resumed", risesCnt - rb, 8);
    check(irqs == 0, "R7", "second stall quiet", irqs, 0);
    rxEnable = 1'b0;
    readPulse();
    check(rdData == 8'h4E && rxIrq == 1'b1, "R8", "third byte moved",
          rdData, 8'h4E);
    @(negedge clk);
    readPulse();
    check(bufFull == 1'b0, "R9", "double read clears", bufFull, 0);
    rb = risesCnt;
    quietFor(100, irqs);
    check(risesCnt == rb, "R4", "stays idle when disabled", risesCnt - rb, 0);

    // R4 disable in mid-frame: frame completes, no further burst
    dblBuf = 1'b1; divHalf = 8'd2;
    pushByte(8'h6D); pushByte(8'hAA);
    rxEnable = 1'b1;
    repeat (10) @(negedge clk);
    rxEnable = 1'b0;
    waitIrq("R4", got);
    check(rdData == 8'h6D, "R4", "frame finished after disable", rdData, 8'h6D);
    rb = risesCnt;
    quietFor(150, irqs);
    check(risesCnt == rb, "R4", "no burst after frame", risesCnt - rb, 0);
    readPulse();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule